// File: doc/BRIEF.md
# Inverse-Mapping Rotation Address Generator

This block drives the read side of an image rotator. Once started, it walks the output raster row by row, one pixel per clock. For each output pixel it applies the inverse rotation about a programmable centre and finds the source pixel that should supply the value. The result is either a linear read address into the source frame or, when the mapped point falls outside that frame, a programmable background value together with an outside flag.

Every output position gets exactly one answer, so the rotated image has no holes. The fractional source position is rounded to the nearest pixel, which gives nearest-neighbour sampling.

The angle is given as signed Q1.14 sine and cosine words. These words, the centre, the frame size and the background value are all captured when a start is accepted. They stay fixed for that frame, so the inputs may change while the frame is running.

Top module: `rot_addr_gen`

## Requirements
- R1: After reset, valid_o and outside_o are low, and no result appears until a start is accepted.
- R2: An accepted start scans W·H output pixels in row order, with x running fastest, from (0,0) to (W-1,H-1). The frame gives exactly W·H results on consecutive cycles and then valid_o falls (W,H ≥ 1).
- R3: valid_o first rises at the fifth rising clock edge, counting as the first the edge that samples start_i high.
- R4: For output pixel (x,y), the source point is sx = c·(x−cx) + s·(y−cy) + cx and sy = −s·(x−cx) + c·(y−cy) + cy. Here s and c are signed Q1.14 values, so 16384 means 1.0.
- R5: Each fractional coordinate v is rounded half up, as floor(v·16384 + 8192) / 16384 with a floor division. A value of −0.5 therefore becomes 0 and +0.5 becomes 1.
- R6: A source point with 0 ≤ sx < W and 0 ≤ sy < H gives outside_o = 0 and data_o = sy·W + sx.
- R7: A source point with sx < 0, sx ≥ W, sy < 0 or sy ≥ H gives outside_o = 1 and data_o = the background value, zero-extended.
- R8: start_i is ignored while a frame is scanning or any result is still in the pipeline. Changes to the angle, centre, size or background inputs after acceptance have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a frame |
| sin_i | input | TRIG_W | Sine of the angle, signed Q1.14 |
| cos_i | input | TRIG_W | Cosine of the angle, signed Q1.14 |
| cx_i | input | COORD_W | Rotation centre, x |
| cy_i | input | COORD_W | Rotation centre, y |
| width_i | input | COORD_W | Frame width W |
| height_i | input | COORD_W | Frame height H |
| bg_i | input | BG_W | Background value for outside pixels |
| valid_o | output | 1 | Result valid |
| outside_o | output | 1 | Mapped point lies outside the source frame |
| data_o | output | max(2·COORD_W, BG_W) | Source address, or background value when outside |

## Verification
The hardest case to reach from the ports is an exact half-pixel tie, most of all the negative tie at −0.5. With a floor-based shift this tie must land on 0, not on −1. A cosine of 0.5 with zero sine makes every odd offset from the centre a tie of either sign, so one small frame covers both directions on both axes. The other hard case is a start request arriving mid-frame together with new parameters. The bench drives exactly that a few cycles into a running frame. It then checks that the delivered results and their count still follow the original setup.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned COORD_W_D = 11;
  localparam int unsigned TRIG_W_D  = 16;
  localparam int unsigned FRAC_W_D  = 14;
  localparam int unsigned BG_W_D    = 16;
endpackage

// File: rtl/rot_raster_scan.sv
module rot_raster_scan #(
  parameter int unsigned COORD_W = rot_pkg::COORD_W_D,
  parameter int unsigned TRIG_W  = rot_pkg::TRIG_W_D,
  parameter int unsigned BG_W    = rot_pkg::BG_W_D
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      pipe_busy_i,
  input  logic signed [TRIG_W-1:0]  sin_i,
  input  logic signed [TRIG_W-1:0]  cos_i,
  input  logic [COORD_W-1:0]        cx_i,
  input  logic [COORD_W-1:0]        cy_i,
  input  logic [COORD_W-1:0]        width_i,
  input  logic [COORD_W-1:0]        height_i,
  input  logic [BG_W-1:0]           bg_i,
  output logic signed [TRIG_W-1:0]  sin_o,
  output logic signed [TRIG_W-1:0]  cos_o,
  output logic [COORD_W-1:0]        cx_o,
  output logic [COORD_W-1:0]        cy_o,
  output logic [COORD_W-1:0]        width_o,
  output logic [COORD_W-1:0]        height_o,
  output logic [BG_W-1:0]           bg_o,
  output logic                      pix_valid_o,
  output logic [COORD_W-1:0]        x_o,
  output logic [COORD_W-1:0]        y_o
);
  logic                     active_q;
  logic [COORD_W-1:0]       x_q, y_q;
  logic signed [TRIG_W-1:0] sin_q, cos_q;
  logic [COORD_W-1:0]       cx_q, cy_q, width_q, height_q;
  logic [BG_W-1:0]          bg_q;
  logic                     accept, last_x, last_y;

  assign accept = start_i && !active_q && !pipe_busy_i;
  assign last_x = (x_q == width_q - COORD_W'(1));
  assign last_y = (y_q == height_q - COORD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      sin_q    <= '0;
      cos_q    <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      width_q  <= '0;
      height_q <= '0;
      bg_q     <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      x_q      <= '0;
      y_q      <= '0;
      sin_q    <= sin_i;
      cos_q    <= cos_i;
      cx_q     <= cx_i;
      cy_q     <= cy_i;
      width_q  <= width_i;
      height_q <= height_i;
      bg_q     <= bg_i;
    end else if (active_q) begin
      if (last_x) begin
        x_q <= '0;
        if (last_y) active_q <= 1'b0;
        else        y_q      <= y_q + COORD_W'(1);
      end else begin
        x_q <= x_q + COORD_W'(1);
      end
    end
  end

  assign sin_o       = sin_q;
  assign cos_o       = cos_q;
  assign cx_o        = cx_q;
  assign cy_o        = cy_q;
  assign width_o     = width_q;
  assign height_o    = height_q;
  assign bg_o        = bg_q;
  assign pix_valid_o = active_q;
  assign x_o         = x_q;
  assign y_o         = y_q;

  p_coord_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (x_q < width_q) && (y_q < height_q));

  p_hold_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (active_q || pipe_busy_i)) |=>
      $stable(sin_q) && $stable(cos_q) && $stable(cx_q) && $stable(cy_q) &&
      $stable(width_q) && $stable(height_q) && $stable(bg_q));
endmodule

// File: rtl/rot_inv_map.sv
module rot_inv_map #(
  parameter int unsigned COORD_W = rot_pkg::COORD_W_D,
  parameter int unsigned TRIG_W  = rot_pkg::TRIG_W_D,
  parameter int unsigned FRAC_W  = rot_pkg::FRAC_W_D,
  localparam int unsigned DW     = COORD_W + 1,
  localparam int unsigned PW     = DW + TRIG_W,
  localparam int unsigned SW     = PW + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [COORD_W-1:0]        x_i,
  input  logic [COORD_W-1:0]        y_i,
  input  logic [COORD_W-1:0]        cx_i,
  input  logic [COORD_W-1:0]        cy_i,
  input  logic signed [TRIG_W-1:0]  sin_i,
  input  logic signed [TRIG_W-1:0]  cos_i,
  output logic                      valid_o,
  output logic signed [SW-1:0]      src_x_o,
  output logic signed [SW-1:0]      src_y_o,
  output logic                      busy_o
);
  localparam int HALF = 1 << (FRAC_W - 1);

  logic                 v1_q, v2_q, v3_q;
  logic signed [DW-1:0] dx_q, dy_q;
  logic signed [PW-1:0] pxc_q, pys_q, pxs_q, pyc_q;
  logic signed [SW-1:0] sx_q, sy_q;
  logic signed [DW-1:0] cx_s, cy_s;
  logic signed [SW-1:0] sum_x, sum_y, flr_x, flr_y;

  assign cx_s = $signed({1'b0, cx_i});
  assign cy_s = $signed({1'b0, cy_i});

  // round half up: add one half, then floor via arithmetic shift
  assign sum_x = SW'(pxc_q) + SW'(pys_q) + SW'(HALF);
  assign sum_y = SW'(pyc_q) - SW'(pxs_q) + SW'(HALF);
  assign flr_x = sum_x >>> FRAC_W;
  assign flr_y = sum_y >>> FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      dx_q  <= '0;
      dy_q  <= '0;
      pxc_q <= '0;
      pys_q <= '0;
      pxs_q <= '0;
      pyc_q <= '0;
      sx_q  <= '0;
      sy_q  <= '0;
    end else begin
      v1_q <= valid_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
      if (valid_i) begin
        dx_q <= $signed({1'b0, x_i}) - cx_s;
        dy_q <= $signed({1'b0, y_i}) - cy_s;
      end
      if (v1_q) begin
        pxc_q <= PW'(dx_q) * PW'(cos_i);
        pys_q <= PW'(dy_q) * PW'(sin_i);
        pxs_q <= PW'(dx_q) * PW'(sin_i);
        pyc_q <= PW'(dy_q) * PW'(cos_i);
      end
      if (v2_q) begin
        sx_q <= flr_x + SW'(cx_s);
        sy_q <= flr_y + SW'(cy_s);
      end
    end
  end

  assign valid_o = v3_q;
  assign src_x_o = sx_q;
  assign src_y_o = sy_q;
  assign busy_o  = v1_q | v2_q | v3_q;
endmodule

// File: rtl/rot_bounds_addr.sv
module rot_bounds_addr #(
  parameter int unsigned COORD_W = rot_pkg::COORD_W_D,
  parameter int unsigned SW      = 2 * rot_pkg::COORD_W_D,
  parameter int unsigned BG_W    = rot_pkg::BG_W_D,
  localparam int unsigned ADDR_W = 2 * COORD_W,
  localparam int unsigned OUT_W  = (ADDR_W > BG_W) ? ADDR_W : BG_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [SW-1:0]  src_x_i,
  input  logic signed [SW-1:0]  src_y_i,
  input  logic [COORD_W-1:0]    width_i,
  input  logic [COORD_W-1:0]    height_i,
  input  logic [BG_W-1:0]       bg_i,
  output logic                  valid_o,
  output logic                  outside_o,
  output logic [OUT_W-1:0]      data_o
);
  logic signed [SW-1:0] w_s, h_s;
  logic                 outside_n;
  logic [ADDR_W-1:0]    addr_n;

  assign w_s = $signed(SW'(width_i));
  assign h_s = $signed(SW'(height_i));

  assign outside_n = (src_x_i < 0) || (src_x_i >= w_s) ||
                     (src_y_i < 0) || (src_y_i >= h_s);

  assign addr_n = ADDR_W'(src_y_i[COORD_W-1:0]) * ADDR_W'(width_i) +
                  ADDR_W'(src_x_i[COORD_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      outside_o <= 1'b0;
      data_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        outside_o <= outside_n;
        data_o    <= outside_n ? OUT_W'(bg_i) : OUT_W'(addr_n);
      end
    end
  end

  p_addr_in_image_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !outside_o) |-> (data_o < (OUT_W'(width_i) * OUT_W'(height_i))));
endmodule

// File: rtl/rot_addr_gen.sv
module rot_addr_gen #(
  parameter int unsigned COORD_W = rot_pkg::COORD_W_D,
  parameter int unsigned TRIG_W  = rot_pkg::TRIG_W_D,
  parameter int unsigned FRAC_W  = rot_pkg::FRAC_W_D,
  parameter int unsigned BG_W    = rot_pkg::BG_W_D,
  localparam int unsigned ADDR_W = 2 * COORD_W,
  localparam int unsigned OUT_W  = (ADDR_W > BG_W) ? ADDR_W : BG_W,
  localparam int unsigned SW     = COORD_W + 1 + TRIG_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [TRIG_W-1:0] sin_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  input  logic [COORD_W-1:0]       cx_i,
  input  logic [COORD_W-1:0]       cy_i,
  input  logic [COORD_W-1:0]       width_i,
  input  logic [COORD_W-1:0]       height_i,
  input  logic [BG_W-1:0]          bg_i,
  output logic                     valid_o,
  output logic                     outside_o,
  output logic [OUT_W-1:0]         data_o
);
  logic signed [TRIG_W-1:0] sin_l, cos_l;
  logic [COORD_W-1:0]       cx_l, cy_l, width_l, height_l;
  logic [BG_W-1:0]          bg_l;
  logic                     pix_valid;
  logic [COORD_W-1:0]       pix_x, pix_y;
  logic                     map_valid, map_busy, pipe_busy;
  logic signed [SW-1:0]     src_x, src_y;

  assign pipe_busy = map_busy | valid_o;

  rot_raster_scan #(
    .COORD_W(COORD_W), .TRIG_W(TRIG_W), .BG_W(BG_W)
  ) u_scan (
    .clk_i, .rst_ni, .start_i,
    .pipe_busy_i (pipe_busy),
    .sin_i, .cos_i, .cx_i, .cy_i, .width_i, .height_i, .bg_i,
    .sin_o       (sin_l),
    .cos_o       (cos_l),
    .cx_o        (cx_l),
    .cy_o        (cy_l),
    .width_o     (width_l),
    .height_o    (height_l),
    .bg_o        (bg_l),
    .pix_valid_o (pix_valid),
    .x_o         (pix_x),
    .y_o         (pix_y)
  );

  rot_inv_map #(
    .COORD_W(COORD_W), .TRIG_W(TRIG_W), .FRAC_W(FRAC_W)
  ) u_map (
    .clk_i, .rst_ni,
    .valid_i (pix_valid),
    .x_i     (pix_x),
    .y_i     (pix_y),
    .cx_i    (cx_l),
    .cy_i    (cy_l),
    .sin_i   (sin_l),
    .cos_i   (cos_l),
    .valid_o (map_valid),
    .src_x_o (src_x),
    .src_y_o (src_y),
    .busy_o  (map_busy)
  );

  rot_bounds_addr #(
    .COORD_W(COORD_W), .SW(SW), .BG_W(BG_W)
  ) u_bounds (
    .clk_i, .rst_ni,
    .valid_i   (map_valid),
    .src_x_i   (src_x),
    .src_y_i   (src_y),
    .width_i   (width_l),
    .height_i  (height_l),
    .bg_i      (bg_l),
    .valid_o,
    .outside_o,
    .data_o
  );

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(pix_valid, 4));

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_valid && !map_busy) |=> !valid_o);
endmodule

// File: tb/rot_addr_gen_tb.sv
module rot_addr_gen_tb;
  localparam int COORD_W = 11;
  localparam int TRIG_W  = 16;
  localparam int BG_W    = 16;
  localparam int OUT_W   = 22;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     start = 1'b0;
  logic signed [TRIG_W-1:0] sin_v = '0, cos_v = '0;
  logic [COORD_W-1:0]       cx = '0, cy = '0, wd = '0, ht = '0;
  logic [BG_W-1:0]          bg = '0;
  logic                     valid_o, outside_o;
  logic [OUT_W-1:0]         data_o;

  typedef struct {
    bit           outside;
    longint       data;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #2ns clk = ~clk;

  rot_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .sin_i(sin_v), .cos_i(cos_v), .cx_i(cx), .cy_i(cy),
    .width_i(wd), .height_i(ht), .bg_i(bg),
    .valid_o, .outside_o, .data_o
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard driver side: expected results from the requirement formulas
  task automatic push_frame(input int s, input int c, input int pcx, input int pcy,
                            input int w, input int h, input int pbg, input string tag);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        longint dx = x - pcx;
        longint dy = y - pcy;
        longint ax = dx * c + dy * s + 8192;
        longint ay = dy * c - dx * s + 8192;
        longint sx = (ax >>> 14) + pcx;
        longint sy = (ay >>> 14) + pcy;
        exp_t   e;
        e.outside = (sx < 0) || (sx >= w) || (sy < 0) || (sy >= h);
        e.data    = e.outside ? longint'(pbg) : (sy * w + sx);
        e.tag     = {tag, e.outside ? "/R7" : "/R6"};
        q.push_back(e);
      end
    end
  endtask

  task automatic run_frame(input int s, input int c, input int pcx, input int pcy,
                           input int w, input int h, input int pbg, input string tag,
                           input bit meas_lat, input bit poke);
    int lat = 0;
    push_frame(s, c, pcx, pcy, w, h, pbg, tag);
    @(negedge clk);
    sin_v = TRIG_W'(s); cos_v = TRIG_W'(c);
    cx = COORD_W'(pcx); cy = COORD_W'(pcy);
    wd = COORD_W'(w);   ht = COORD_W'(h);
    bg = BG_W'(pbg);
    start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    if (meas_lat) begin
      while (!valid_o && lat < 50) begin
        @(posedge clk); lat++;
        @(negedge clk);
      end
      check(lat == 5, "R3 first-valid edge", lat, 5);
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      // R8: new parameters and a start while the frame runs
      sin_v = 16'sd9000; cos_v = -16'sd3000; cx = 11'd1; cy = 11'd1;
      wd = 11'd3; ht = 11'd3; bg = 16'h1234;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(q.size() == 0, "R2 all results delivered", q.size(), 0);
    check(!valid_o, "R2 valid low after frame", valid_o, 0);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R2/R8 unexpected result", longint'(data_o), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(outside_o == e.outside, {e.tag, " outside flag"}, outside_o, e.outside);
        check(longint'(data_o) == e.data, {e.tag, " data"}, longint'(data_o), e.data);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4ns);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(!valid_o && !outside_o, "R1 idle after reset", {valid_o, outside_o}, 0);
    end
    // identity, with latency measurement
    run_frame(0, 16384, 3, 2, 8, 6, 16'h00AA, "R4 identity", 1'b1, 1'b0);
    // half turn: many pixels fall outside
    run_frame(0, -16384, 2, 1, 7, 5, 16'hA5C3, "R4 half-turn", 1'b0, 1'b0);
    // quarter turn
    run_frame(16384, 0, 3, 2, 6, 6, 16'hFFFF, "R4 quarter-turn", 1'b0, 1'b0);
    // thirty degrees, mid-frame restart attempt with new inputs
    run_frame(8192, 14189, 4, 3, 9, 7, 16'h0101, "R4/R8 30deg", 1'b0, 1'b1);
    // cos 0.5: +0.5 and -0.5 ties (x=5 -> 5, x=3 -> 4, x=0 -> 2)
    run_frame(0, 8192, 4, 0, 8, 2, 16'h0F0F, "R5 ties", 1'b0, 1'b0);
    // sin and cos 0.5: ties on both axes, both signs
    run_frame(8192, 8192, 3, 3, 7, 7, 16'h0042, "R5 ties-xy", 1'b0, 1'b0);
    // single-pixel frame
    run_frame(0, 16384, 0, 0, 1, 1, 16'h0007, "R2 one-pixel", 1'b1, 1'b0);
    finish_run();
  end
endmodule